// File: doc/BRIEF.md
# Four-Way Sub-Banked Data SRAM with Processor/DMA Arbitration

This block is a 16 KB on-chip data memory made of four 4 KB sub-banks. It has two request ports, one for the processor and one for a DMA engine. Each port carries 32-bit words with byte enables and uses a valid/ready handshake. The top address bits pick the sub-bank. When the two ports target different sub-banks in the same cycle, both are accepted together and neither pays any latency. When both target the same sub-bank, an arbiter serves the processor. The DMA port is held off with ready low. A loss counter makes sure the DMA port is served after a bounded number of lost cycles.

Read data comes back one cycle after the read is accepted, together with a return-valid strobe. The same module, built with its DMA port disabled by a parameter, serves as a processor-only scratchpad that never accepts a DMA request.

Top module: `subbank_sram`

## Requirements
- R1: The bank holds 4096 words of 32 bits. The sub-bank is addr[13:12] (values 0 to 3) and the word within it is addr[11:2]. Addresses are word aligned, so addr[1:0] is 0. Every word of all four sub-banks keeps the last value written to it.
- R2: Requests from both ports that target different sub-banks are both accepted in the same cycle.
- R3: A valid request that does not collide is accepted in the same cycle: ready is high while valid is high, with no wait cycle.
- R4: When both ports are valid and target the same sub-bank, the processor port is accepted and dma_ready is low. This holds unless the R5 rule applies. A stalled request keeps its valid, address, data and enables stable until it is accepted.
- R5: After the DMA port has lost four collisions in a row, its next collision is granted to DMA and core_ready is low for that cycle. The loss count returns to zero whenever a DMA request is accepted.
- R6: For an accepted read (we = 0), rvalid is high in the next cycle and rdata holds the word stored at that address. rvalid is low after any cycle with no accepted read on that port.
- R7: On an accepted write, byte enable bit b writes data bits [8b+7:8b]. Bytes whose enable is 0 keep their old value.
- R8: With DMA_EN = 0, dma_ready stays low and a DMA request never changes the memory contents.
- R9: While rst_n is low, both ready outputs and both rvalid outputs are low. The loss count starts at zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Processor request valid |
| core_ready | output | 1 | Processor request accepted this cycle |
| core_we | input | 1 | Processor write (1) or read (0) |
| core_addr | input | 14 | Processor byte address in the bank |
| core_be | input | 4 | Processor byte enables |
| core_wdata | input | 32 | Processor write data |
| core_rvalid | output | 1 | Processor read data valid |
| core_rdata | output | 32 | Processor read data |
| dma_valid | input | 1 | DMA request valid |
| dma_ready | output | 1 | DMA request accepted this cycle |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 14 | DMA byte address in the bank |
| dma_be | input | 4 | DMA byte enables |
| dma_wdata | input | 32 | DMA write data |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 32 | DMA read data |

## Verification
The bench stages a run of same-sub-bank collisions. It expects exactly four DMA stall cycles and then a DMA grant that stalls the processor. A design that ignores the loss count would starve DMA. A design that counts off by one would grant one cycle early or late, and a design that never clears the count would grant DMA too often afterwards.

The bench fills both halves of the bank concurrently from the two ports. It then reads back the top word of each sub-bank, which exposes a wrong sub-bank select or a word index that aliases. A partial byte-enable write catches bytes that are clobbered when their enable is 0.

Random mixed traffic is biased toward collisions and compared every clock against a behavioural model. This catches a read whose data returns in the wrong cycle or from the wrong sub-bank. A second instance built without DMA checks that a DMA write that is held valid never lands in memory.

// File: rtl/subbank_sram_pkg.sv
// Shared types for the sub-banked SRAM.
// Assumes: nothing beyond IEEE 1800-2017.
package subbank_sram_pkg;

    // Which port is using a sub-bank in a given cycle.
    typedef enum logic {
        PORT_CORE = 1'b0,
        PORT_DMA  = 1'b1
    } port_e;

    // Default number of consecutive lost collisions before DMA is forced.
    localparam int FAIR_LIMIT_DEFAULT = 4;

endpackage

// File: rtl/subbank_sram_arbiter.sv
// Grant logic for two request ports sharing a set of sub-banks.
// What it does: grants both ports when they address different sub-banks,
// favours the processor on a collision, and forces a DMA grant after
// FAIR_LIMIT consecutive lost collisions.
// Assumes: a stalled DMA request is held until granted; ready outputs are
// combinational from the requests of the same cycle.
module subbank_sram_arbiter #(
    parameter int SEL_W      = 2,
    parameter int FAIR_LIMIT = 4,
    parameter bit DMA_EN     = 1'b1,
    localparam int CNT_W     = $clog2(FAIR_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_valid,
    input  logic [SEL_W-1:0] core_sel,
    input  logic             dma_valid,
    input  logic [SEL_W-1:0] dma_sel,
    output logic             core_grant,
    output logic             dma_grant
);

    logic             collide;
    logic             forced;
    logic [CNT_W-1:0] loss_cnt;

    // Detect a same-sub-bank collision and whether fairness is due.
    always_comb begin
        collide = core_valid && dma_valid && (core_sel == dma_sel);
        forced  = (loss_cnt == CNT_W'(FAIR_LIMIT));
    end

    // Pick the winners for this cycle.
    always_comb begin
        dma_grant  = DMA_EN && rst_n && dma_valid && (!collide || forced);
        core_grant = rst_n && core_valid && !(collide && dma_grant);
    end

    // Count consecutive DMA losses; clear on any DMA acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loss_cnt <= '0;
        end else if (dma_grant) begin
            loss_cnt <= '0;
        end else if (collide && !forced) begin
            loss_cnt <= loss_cnt + 1'b1;
        end
    end

    // R5: the loss count never passes its limit.
    p_fair_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        loss_cnt <= CNT_W'(FAIR_LIMIT));

    // R5: after the last tolerated loss, a repeated collision goes to DMA.
    if (DMA_EN) begin : g_fair_chk
        p_forced_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (collide && !dma_grant && loss_cnt == CNT_W'(FAIR_LIMIT - 1))
            |=> (!(core_valid && dma_valid && core_sel == dma_sel) || dma_grant));
    end

endmodule

// File: rtl/subbank_sram_bank.sv
// One sub-bank: a single-ported word array with byte-enable writes and a
// registered read. Either port may own it in a cycle, never both.
// Assumes: the arbiter gives ownership to at most one port per cycle.
module subbank_sram_bank
    import subbank_sram_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORDS  = 1024,
    localparam int BE_W  = DATA_W / 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_en,
    input  logic              core_we,
    input  logic [BE_W-1:0]   core_be,
    input  logic [IDX_W-1:0]  core_idx,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              dma_en,
    input  logic              dma_we,
    input  logic [BE_W-1:0]   dma_be,
    input  logic [IDX_W-1:0]  dma_idx,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];
    port_e             owner;
    logic              en;
    logic              we;
    logic [BE_W-1:0]   be;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;

    // Select the fields of the owning port.
    always_comb begin
        owner = dma_en ? PORT_DMA : PORT_CORE;
        en    = core_en || dma_en;
        we    = (owner == PORT_DMA) ? dma_we    : core_we;
        be    = (owner == PORT_DMA) ? dma_be    : core_be;
        idx   = (owner == PORT_DMA) ? dma_idx   : core_idx;
        wdata = (owner == PORT_DMA) ? dma_wdata : core_wdata;
    end

    // Write enabled bytes or register the addressed word.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (be[b]) begin
                        mem[idx][8*b +: 8] <= wdata[8*b +: 8];
                    end
                end
            end else begin
                rdata <= mem[idx];
            end
        end
    end

    // R2: a sub-bank is never driven by both ports in one cycle.
    p_single_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_en && dma_en));

endmodule

// File: rtl/subbank_sram_rdret.sv
// Read-return path for one port: remembers which sub-bank a read went to
// and presents that sub-bank's registered word with a valid strobe.
// Assumes: sub-bank read data is registered at the same edge as rvalid.
module subbank_sram_rdret #(
    parameter int DATA_W  = 32,
    parameter int NUM_SUB = 4,
    localparam int SEL_W  = $clog2(NUM_SUB)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_acc,
    input  logic [SEL_W-1:0]                rd_sel,
    input  logic [NUM_SUB-1:0][DATA_W-1:0]  sub_rdata,
    output logic                            rvalid,
    output logic [DATA_W-1:0]               rdata
);

    logic [SEL_W-1:0] sel_q;

    // Track the pending read and the sub-bank it targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            sel_q  <= '0;
        end else begin
            rvalid <= rd_acc;
            if (rd_acc) begin
                sel_q <= rd_sel;
            end
        end
    end

    // Steer the selected sub-bank's word to the port.
    always_comb begin
        rdata = sub_rdata[sel_q];
    end

endmodule

// File: rtl/subbank_sram.sv
// Top of the sub-banked data SRAM: splits the bank into NUM_SUB sub-banks,
// arbitrates the processor and DMA ports per sub-bank, and returns read data
// one cycle after acceptance.
// Assumes: word-aligned addresses; requests held stable until ready;
// DMA_EN = 0 builds a processor-only instance.
module subbank_sram
    import subbank_sram_pkg::*;
#(
    parameter int BANK_BYTES = 16384,
    parameter int NUM_SUB    = 4,
    parameter int DATA_W     = 32,
    parameter int FAIR_LIMIT = FAIR_LIMIT_DEFAULT,
    parameter bit DMA_EN     = 1'b1,
    localparam int ADDR_W    = $clog2(BANK_BYTES),
    localparam int BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    output logic              core_ready,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [BE_W-1:0]   core_be,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_rvalid,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              dma_valid,
    output logic              dma_ready,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [BE_W-1:0]   dma_be,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              dma_rvalid,
    output logic [DATA_W-1:0] dma_rdata
);

    localparam int SEL_W = $clog2(NUM_SUB);
    localparam int OFF_W = $clog2(BE_W);
    localparam int WORDS = BANK_BYTES / NUM_SUB / BE_W;
    localparam int IDX_W = $clog2(WORDS);

    logic [SEL_W-1:0]               core_sel, dma_sel;
    logic [IDX_W-1:0]               core_idx, dma_idx;
    logic                           core_grant, dma_grant;
    logic [NUM_SUB-1:0][DATA_W-1:0] sub_rdata;

    // Decode sub-bank and word index from the byte addresses.
    always_comb begin
        core_sel = core_addr[ADDR_W-1 -: SEL_W];
        dma_sel  = dma_addr[ADDR_W-1 -: SEL_W];
        core_idx = core_addr[OFF_W +: IDX_W];
        dma_idx  = dma_addr[OFF_W +: IDX_W];
    end

    subbank_sram_arbiter #(
        .SEL_W      (SEL_W),
        .FAIR_LIMIT (FAIR_LIMIT),
        .DMA_EN     (DMA_EN)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_valid (core_valid),
        .core_sel   (core_sel),
        .dma_valid  (dma_valid),
        .dma_sel    (dma_sel),
        .core_grant (core_grant),
        .dma_grant  (dma_grant)
    );

    assign core_ready = core_grant;
    assign dma_ready  = dma_grant;

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        subbank_sram_bank #(
            .DATA_W (DATA_W),
            .WORDS  (WORDS)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .core_en    (core_grant && (core_sel == SEL_W'(s))),
            .core_we    (core_we),
            .core_be    (core_be),
            .core_idx   (core_idx),
            .core_wdata (core_wdata),
            .dma_en     (dma_grant && (dma_sel == SEL_W'(s))),
            .dma_we     (dma_we),
            .dma_be     (dma_be),
            .dma_idx    (dma_idx),
            .dma_wdata  (dma_wdata),
            .rdata      (sub_rdata[s])
        );
    end

    subbank_sram_rdret #(
        .DATA_W  (DATA_W),
        .NUM_SUB (NUM_SUB)
    ) u_core_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_acc    (core_grant && !core_we),
        .rd_sel    (core_sel),
        .sub_rdata (sub_rdata),
        .rvalid    (core_rvalid),
        .rdata     (core_rdata)
    );

    subbank_sram_rdret #(
        .DATA_W  (DATA_W),
        .NUM_SUB (NUM_SUB)
    ) u_dma_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_acc    (dma_grant && !dma_we),
        .rd_sel    (dma_sel),
        .sub_rdata (sub_rdata),
        .rvalid    (dma_rvalid),
        .rdata     (dma_rdata)
    );

    // R1: only word-aligned requests are presented.
    p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid |-> core_addr[OFF_W-1:0] == '0) and
        (dma_valid  |-> dma_addr[OFF_W-1:0]  == '0));

    // R3: a processor request with no colliding DMA request is taken at once.
    p_free_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !(dma_valid && dma_sel == core_sel)) |-> core_ready);

    // R6: an accepted read returns valid data on the next cycle.
    p_read_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && core_ready && !core_we) |=> core_rvalid);

    if (DMA_EN) begin : g_dma_chk
        // R4: a stalled DMA request stays put until it is accepted.
        p_dma_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr)));
    end else begin : g_no_dma_chk
        // R8: a processor-only instance never accepts DMA.
        p_no_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !dma_ready && !dma_rvalid);
    end

endmodule

// File: tb/subbank_sram_tb.sv
// Self-checking bench: a behavioural model (flat word array, loss counter)
// predicts ready, rvalid and rdata every cycle for the main instance; a
// second instance without DMA checks the rejection path.
module subbank_sram_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cv = 1'b0, cwe = 1'b0, dv = 1'b0, dwe = 1'b0;
    logic [13:0] ca = '0, da = '0;
    logic [3:0]  cbe = '0, dbe = '0;
    logic [31:0] cwd = '0, dwd = '0;
    logic        cr, crv, dr, drv;
    logic [31:0] crd, drd;

    logic        s_cv = 1'b0, s_cwe = 1'b0, s_dv = 1'b0;
    logic [13:0] s_ca = '0, s_da = '0;
    logic [31:0] s_cwd = '0, s_dwd = '0;
    logic        s_cr, s_crv, s_dr, s_drv;
    logic [31:0] s_crd, s_drd;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          fair_cnt = 0;
    bit          c_acc, d_acc;
    bit          exp_crv, exp_drv;
    logic [31:0] exp_crd, exp_drd;
    logic [31:0] ref_mem [4096];
    bit          finished = 1'b0;

    always #2.5ns clk = ~clk;

    subbank_sram u_dut (
        .clk (clk), .rst_n (rst_n),
        .core_valid (cv), .core_ready (cr), .core_we (cwe), .core_addr (ca),
        .core_be (cbe), .core_wdata (cwd), .core_rvalid (crv), .core_rdata (crd),
        .dma_valid (dv), .dma_ready (dr), .dma_we (dwe), .dma_addr (da),
        .dma_be (dbe), .dma_wdata (dwd), .dma_rvalid (drv), .dma_rdata (drd)
    );

    subbank_sram #(.DMA_EN (1'b0)) u_scratch (
        .clk (clk), .rst_n (rst_n),
        .core_valid (s_cv), .core_ready (s_cr), .core_we (s_cwe), .core_addr (s_ca),
        .core_be (4'hF), .core_wdata (s_cwd), .core_rvalid (s_crv), .core_rdata (s_crd),
        .dma_valid (s_dv), .dma_ready (s_dr), .dma_we (1'b1), .dma_addr (s_da),
        .dma_be (4'hF), .dma_wdata (s_dwd), .dma_rvalid (s_drv), .dma_rdata (s_drd)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // One clock: inputs were set at the previous falling edge.
    task automatic step();
        bit coll, ec, ed;
        string tg;
        #1ns;
        coll = cv && dv && (ca[13:12] == da[13:12]);
        ed   = dv && (!coll || fair_cnt >= 4);
        ec   = cv && !(coll && ed);
        tg   = coll ? ((fair_cnt >= 4) ? "R5" : "R4") : ((cv && dv) ? "R2" : "R3");
        chk(cr === ec, tg, "core_ready", 32'(cr), 32'(ec));
        chk(dr === ed, tg, "dma_ready",  32'(dr), 32'(ed));
        c_acc = ec;
        d_acc = ed;
        @(posedge clk);
        exp_crv = ec && !cwe;
        exp_drv = ed && !dwe;
        if (exp_crv) exp_crd = ref_mem[ca[13:2]];
        if (exp_drv) exp_drd = ref_mem[da[13:2]];
        if (ec && cwe) ref_mem[ca[13:2]] = merge(ref_mem[ca[13:2]], cwd, cbe);
        if (ed && dwe) ref_mem[da[13:2]] = merge(ref_mem[da[13:2]], dwd, dbe);
        if (dv) begin
            if (ed) fair_cnt = 0;
            else if (fair_cnt < 4) fair_cnt++;
        end
        @(negedge clk);
        chk(crv === exp_crv, "R6", "core_rvalid", 32'(crv), 32'(exp_crv));
        chk(drv === exp_drv, "R6", "dma_rvalid",  32'(drv), 32'(exp_drv));
        if (exp_crv) chk(crd === exp_crd, "R6", "core_rdata", crd, exp_crd);
        if (exp_drv) chk(drd === exp_drd, "R6", "dma_rdata",  drd, exp_drd);
    endtask

    initial begin
        #750us;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset holds the handshake and return strobes low.
        cv = 1'b1; dv = 1'b1; ca = 14'h0100; da = 14'h0200;
        repeat (3) @(negedge clk);
        chk(cr === 1'b0 && dr === 1'b0, "R9", "ready in reset", {cr, dr}, 0);
        chk(crv === 1'b0 && drv === 1'b0, "R9", "rvalid in reset", {crv, drv}, 0);
        cv = 1'b0; dv = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        fair_cnt = 0;

        // R1/R2: fill sub-banks 0-1 from the processor, 2-3 from DMA at once.
        cv = 1'b1; cwe = 1'b1; cbe = 4'hF;
        dv = 1'b1; dwe = 1'b1; dbe = 4'hF;
        for (int i = 0; i < 2048; i++) begin
            ca  = {1'b0, 11'(i), 2'b00};
            da  = {1'b1, 11'(i), 2'b00};
            cwd = 32'hC0DE0000 ^ 32'(i);
            dwd = 32'hD0A00000 ^ 32'(i);
            step();
        end
        dv = 1'b0;

        // R1: top word of every sub-bank reads back its own fill value.
        cwe = 1'b0;
        for (int s = 0; s < 4; s++) begin
            logic [31:0] ev;
            ca = {2'(s), 10'h3FF, 2'b00};
            ev = ((s >= 2) ? 32'hD0A00000 : 32'hC0DE0000) ^ 32'({s[0], 10'h3FF});
            step();
            chk(crd === ev, "R1", "sub-bank top word", crd, ev);
        end

        // R4/R5: processor streams reads into sub-bank 1, DMA writes there.
        begin
            int waits = 0;
            int caddr = 0;
            ca = {2'd1, 10'(caddr), 2'b00};
            dv = 1'b1; dwe = 1'b1; da = 14'h1010; dbe = 4'hF; dwd = 32'hFEEDF00D;
            for (int k = 0; k < 12; k++) begin
                step();
                if (d_acc) break;
                waits++;
                if (c_acc) begin
                    caddr++;
                    ca = {2'd1, 10'(caddr), 2'b00};
                end
            end
            chk(waits == 4, "R5", "DMA stall cycles before forced grant", 32'(waits), 32'd4);
            chk(!c_acc, "R5", "core stalled on forced cycle", 32'(c_acc), 0);
            dv = 1'b0;
            step();
        end

        // R7: partial byte-enable write keeps the masked bytes.
        cwe = 1'b1; ca = 14'h2020; cbe = 4'hF; cwd = 32'h11223344;
        step();
        cbe = 4'b0101; cwd = 32'hAABBCCDD;
        step();
        cwe = 1'b0; cbe = 4'hF;
        step();
        chk(crd === 32'h11BB33DD, "R7", "byte-enable merge", crd, 32'h11BB33DD);
        cv = 1'b0;
        step();

        // Random traffic biased to collide; requests held until accepted.
        c_acc = 1'b0; d_acc = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            if (!cv || c_acc) begin
                int unsigned r;
                r   = $urandom;
                cv  = (r[3:0] < 4'd11);
                cwe = r[4];
                ca  = {r[16:5], 2'b00};
                cbe = r[20:17];
                cwd = $urandom;
            end
            if (!dv || d_acc) begin
                int unsigned r;
                r   = $urandom;
                dv  = (r[3:0] < 4'd10);
                dwe = r[4];
                da  = {r[16:5], 2'b00};
                if (r[21]) da[13:12] = ca[13:12];
                dbe = r[20:17];
                dwd = $urandom;
            end
            step();
        end
        while (dv && !d_acc) step();
        cv = 1'b0; dv = 1'b0;
        step();

        // R8: processor-only instance refuses a held DMA write.
        s_cv = 1'b1; s_cwe = 1'b1; s_ca = 14'h0100; s_cwd = 32'h5A5A0000;
        @(negedge clk);
        s_cv = 1'b0;
        s_dv = 1'b1; s_da = 14'h0100; s_dwd = 32'hFFFFFFFF;
        for (int k = 0; k < 10; k++) begin
            #1ns;
            chk(s_dr === 1'b0, "R8", "scratch dma_ready", 32'(s_dr), 0);
            @(negedge clk);
        end
        s_dv = 1'b0;
        s_cv = 1'b1; s_cwe = 1'b0;
        @(negedge clk);
        s_cv = 1'b0;
        chk(s_crv === 1'b1, "R8", "scratch rvalid", 32'(s_crv), 1);
        chk(s_crd === 32'h5A5A0000, "R8", "scratch word after DMA attempt", s_crd, 32'h5A5A0000);
        chk(s_drv === 1'b0, "R8", "scratch dma_rvalid", 32'(s_drv), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule